// File: doc/BRIEF.md
# Load-Use Stall Controller

This block decides when a five-stage in-order pipeline must pause for one cycle because an instruction in Decode wants a register that a load in Execute has not yet fetched from data memory. Operands are read in Decode but only written back in Writeback. Results of ordinary instructions in Execute or Memory are forwarded around that gap, so they never need a pause. A load's data, however, does not exist until its Memory stage has run.

When such a dependency is seen, the block raises three hold/flush outputs for exactly one cycle. The program counter and the Fetch/Decode register keep their contents, and Execute receives a bubble with its write enables cleared. By the next cycle the load has moved into Memory, where its data can be forwarded, so no second pause is needed. The stall decision is combinational from the current pipeline state. A small register remembers that the previous cycle was a stall, and a saturating counter reports how many stall cycles have occurred.

Top module: `lu_hazard_ctl`

## Requirements
- R1: In a cycle that is not directly after a stall cycle, `pc_hold`, `fd_hold` and `ex_flush` are 1 in that same cycle when `ex_wen`=1, `ex_load`=1, `ex_dst`!=0 and some source i has `dec_use[i]`=1 and `dec_src[i*REG_W +: REG_W]`==`ex_dst` (source 0 in the low bits).
- R2: A source whose use flag is 0 never causes a stall, even if its index matches `ex_dst`.
- R3: An Execute destination of register 0 never causes a stall.
- R4: No stall occurs when `ex_load`=0 or `ex_wen`=0; forwarded results need no pause.
- R5: A stall lasts exactly one cycle: the cycle after a stall cycle never stalls, even if the inputs are unchanged.
- R6: `pc_hold`, `fd_hold` and `ex_flush` are always equal.
- R7: `stall_cnt` rises by one at the clock edge that ends each stall cycle, holds otherwise, and saturates at 2^CNT_W-1.
- R8: While the synchronous `rst` is 1, all three hold outputs are 0. The first clock edge with `rst`=1 clears `stall_cnt` to 0 and clears the memory of a previous stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src | input | NUM_SRC*REG_W | Decode source register indices, source 0 in low bits |
| dec_use | input | NUM_SRC | Per-source flag: the operand is actually read |
| ex_dst | input | REG_W | Destination register of the instruction in Execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| pc_hold | output | 1 | Keep the program counter this cycle |
| fd_hold | output | 1 | Keep the Fetch/Decode register this cycle |
| ex_flush | output | 1 | Send a bubble into Execute this cycle |
| stall_cnt | output | CNT_W | Saturating count of stall cycles |

## Verification
The bench checks that a wrong stall decision shows on the three hold outputs in the same cycle, because they are combinational from the inputs. The one piece of internal state, the marker for the previous stall, has a limited effect when it is wrong. If it is stuck at 1, a genuine load-use pair is missed in the cycle it is presented. If it is stuck at 0, a held hazard stalls for two cycles in a row. Errors in the counter appear on `stall_cnt` one edge after the stall cycle. The bench covers back-to-back load dependencies, an independent instruction after a load, a load to register 0, and saturation with a narrow counter.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

    // Registered state of the stall controller
    typedef struct packed {
        logic stalled; // previous cycle was a stall cycle
    } lu_state_t;

endpackage

// File: rtl/lu_src_cmp.sv
module lu_src_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             used,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    always_comb begin
        hit = used && (src == dst);
    end
endmodule

// File: rtl/lu_stall_ctr.sv
module lu_stall_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (inc && (ctr_q.cnt != CNT_MAX)) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc || (cnt == CNT_MAX)) |=> $stable(cnt));
endmodule

// File: rtl/lu_hazard_ctl.sv
module lu_hazard_ctl
    import lu_hazard_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int CNT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC*REG_W-1:0] dec_src,
    input  logic [NUM_SRC-1:0]       dec_use,
    input  logic [REG_W-1:0]         ex_dst,
    input  logic                     ex_wen,
    input  logic                     ex_load,
    output logic                     pc_hold,
    output logic                     fd_hold,
    output logic                     ex_flush,
    output logic [CNT_W-1:0]         stall_cnt
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_hit;
    logic               load_live;
    logic               stall;
    lu_state_t          state_d, state_q;

    // One comparator per Decode source operand
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        lu_src_cmp #(.REG_W(REG_W)) u_cmp (
            .src  (dec_src[i*REG_W +: REG_W]),
            .used (dec_use[i]),
            .dst  (ex_dst),
            .hit  (src_hit[i])
        );
    end

    always_comb begin
        load_live     = ex_wen && ex_load && (ex_dst != ZERO_REG);
        stall         = !rst && load_live && (|src_hit) && !state_q.stalled;
        state_d       = state_q;
        state_d.stalled = stall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_hold  = stall;
    assign fd_hold  = stall;
    assign ex_flush = stall;

    lu_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .inc (stall),
        .cnt (stall_cnt)
    );

    // R1
    src0_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_wen && ex_load && (ex_dst != ZERO_REG) && dec_use[0] &&
         (dec_src[REG_W-1:0] == ex_dst) && !$past(pc_hold)) |-> pc_hold);

    // R3
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == ZERO_REG) |-> !pc_hold);

    // R4
    non_load_chk: assert property (@(posedge clk) disable iff (rst)
        !(ex_wen && ex_load) |-> !pc_hold);

    // R5
    single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold);

    // R6
    holds_equal_chk: assert property (@(posedge clk)
        (pc_hold == fd_hold) && (fd_hold == ex_flush));

    // R8
    rst_quiet_chk: assert property (@(posedge clk)
        rst |-> (!pc_hold && !fd_hold && !ex_flush));
endmodule

// File: tb/lu_hazard_ctl_tb.sv
module lu_hazard_ctl_tb;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;
    localparam int CW    = 8;
    localparam int CW_S  = 3;
    localparam int SAT_MAX = (1 << CW_S) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC*REG_W-1:0] dec_src = '0;
    logic [NSRC-1:0]       dec_use = '0;
    logic [REG_W-1:0]      ex_dst  = '0;
    logic                  ex_wen  = 1'b0;
    logic                  ex_load = 1'b0;

    logic pc_h, fd_h, ex_f;
    logic [CW-1:0] cnt;
    logic pc_hs, fd_hs, ex_fs;
    logic [CW_S-1:0] cnt_s;

    int tests = 0;
    int fails = 0;
    int exp_cnt = 0;
    int exp_sat = 0;

    always #5 clk = ~clk;

    lu_hazard_ctl #(.REG_W(REG_W), .NUM_SRC(NSRC), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .dec_src(dec_src), .dec_use(dec_use),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .pc_hold(pc_h), .fd_hold(fd_h), .ex_flush(ex_f), .stall_cnt(cnt));

    lu_hazard_ctl #(.REG_W(REG_W), .NUM_SRC(NSRC), .CNT_W(CW_S)) u_dut_sat (
        .clk(clk), .rst(rst), .dec_src(dec_src), .dec_use(dec_use),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .pc_hold(pc_hs), .fd_hold(fd_hs), .ex_flush(ex_fs), .stall_cnt(cnt_s));

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational holds, then counters after the edge
    task automatic cyc(input int sa, input bit ua, input int sb, input bit ub,
                       input int dst, input bit wen, input bit ld,
                       input bit exp_stall, input string req);
        @(negedge clk);
        rst     = 1'b0;
        dec_src = {sb[REG_W-1:0], sa[REG_W-1:0]};
        dec_use = {ub, ua};
        ex_dst  = dst[REG_W-1:0];
        ex_wen  = wen;
        ex_load = ld;
        #1;
        check(req, {29'd0, pc_h, fd_h, ex_f}, exp_stall ? 7 : 0);
        check(req, {29'd0, pc_hs, fd_hs, ex_fs}, exp_stall ? 7 : 0);
        if (exp_stall) begin
            if (exp_cnt < (1 << CW) - 1) exp_cnt++;
            if (exp_sat < SAT_MAX) exp_sat++;
        end
        @(posedge clk);
        #1;
        check("R7", int'(cnt), exp_cnt);
        check("R7", int'(cnt_s), exp_sat);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst     = 1'b1;
        dec_src = {5'd0, 5'd4};
        dec_use = 2'b01;
        ex_dst  = 5'd4;
        ex_wen  = 1'b1;
        ex_load = 1'b1;
        #1;
        check("R8", {29'd0, pc_h, fd_h, ex_f}, 0);
        @(posedge clk);
        #1;
        exp_cnt = 0;
        exp_sat = 0;
        check("R8", int'(cnt), 0);
        check("R8", int'(cnt_s), 0);
    endtask

    task automatic t_load_use_a();
        cyc(1, 1, 0, 0, 1, 1, 1, 1, "R1");
        cyc(1, 1, 0, 0, 1, 0, 0, 0, "R4");
    endtask

    task automatic t_load_use_b();
        cyc(3, 1, 9, 1, 9, 1, 1, 1, "R1");
        cyc(3, 1, 9, 1, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_unused_src();
        cyc(6, 0, 7, 1, 6, 1, 1, 0, "R2");
        cyc(8, 1, 6, 0, 6, 1, 1, 0, "R2");
    endtask

    task automatic t_zero_dst();
        cyc(0, 1, 0, 1, 0, 1, 1, 0, "R3");
    endtask

    task automatic t_non_load();
        cyc(5, 1, 0, 0, 5, 1, 0, 0, "R4");
        cyc(5, 1, 0, 0, 5, 0, 1, 0, "R4");
    endtask

    task automatic t_held_hazard();
        cyc(11, 1, 0, 0, 11, 1, 1, 1, "R1");
        cyc(11, 1, 0, 0, 11, 1, 1, 0, "R5");
    endtask

    // lw r1 ; lw r2,(r1) ; add r3,r2,r4
    task automatic t_back_to_back();
        cyc(1, 1, 0, 0, 1, 1, 1, 1, "R1");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R5");
        cyc(2, 1, 4, 1, 2, 1, 1, 1, "R1");
        cyc(2, 1, 4, 1, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_independent();
        cyc(6, 1, 7, 1, 1, 1, 1, 0, "R1");
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 20; k++) begin
            cyc(12, 1, 0, 0, 12, 1, 1, (k % 2) == 0, "R5");
        end
        check("R7", int'(cnt_s), SAT_MAX);
    endtask

    task automatic t_reset_clears();
        cyc(13, 1, 0, 0, 13, 1, 1, 1, "R1");
        t_reset();
        cyc(13, 1, 0, 0, 13, 1, 1, 1, "R8");
    endtask

    initial begin
        t_reset();
        t_load_use_a();
        t_load_use_b();
        t_unused_src();
        t_zero_dst();
        t_non_load();
        t_held_hazard();
        t_back_to_back();
        t_independent();
        t_saturate();
        t_reset_clears();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule